// File: doc/BRIEF.md
# Dual Servo Pulse Generator with Frame-Synchronous Compare Loading

This block drives two hobby-servo control lines from one shared timebase. A power-of-two prescaler divides the system clock. The divided tick drives a period counter that runs from zero up to one less than its modulus and then wraps. Each output is high-true and edge-aligned: it rises when the counter wraps and falls when the counter reaches that channel's active compare value. The defaults give a 20 ms frame, which is a 50 Hz servo rate. The pulse spans 1.1 ms at one end of travel and 1.48 ms at the other.

Software-side logic or a control loop supplies a signed position for each channel as a Q1.15 number. The block converts it in fixed point into a compare count between the configured minimum and maximum pulse widths. The result goes into that channel's queue register. Queued values move into the active compares only at the counter wrap, so a pulse already in progress is never cut short or stretched.

At every wrap the block also raises a one-cycle frame-start strobe that a downstream sensor sequencer can use. It also advances a frame counter that stops at its all-ones value instead of rolling over.

Top module: `servo_frame_pwm`

## Requirements
- R1: The period counter advances once every 2^PRESC_LOG2 clock cycles and counts 0 to MODV-1, so a frame lasts MODV·2^PRESC_LOG2 cycles. frame_start is high for exactly one cycle per frame, in the cycle in which the counter has just returned to zero.
- R2: Each pwm_out bit is high from the frame_start cycle for active_compare·2^PRESC_LOG2 cycles, then stays low until the next frame_start.
- R3: A position p (Q1.15, signed 16 bits) maps to compare = MIN_CMP + floor(u·(MAX_CMP−MIN_CMP)/65536), where u = p+32768. The full-scale positive code 0x7FFF is clamped to +1 (u = 65536), which gives exactly MAX_CMP. The code 0x8000 (−1) gives MIN_CMP.
- R4: A write (pos_wr[i] high for one cycle, with the value on pos_val[16·i+15:16·i]) changes only the queue. The active compare takes the queued value at the next wrap, and the frame in progress keeps its old width. A write sampled on the same edge as the wrap takes effect one frame later.
- R5: After synchronous reset, both channels hold the neutral compare (p = 0), tick_count is 0, frame_start is 0, the counter is at zero and both outputs are high.
- R6: tick_count increments by one at each wrap, holds at all ones (2^TICK_W−1) once it gets there, and changes at no other time.
- R7: A write to one channel leaves the queue and the output of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_wr | input | NCH | Per-channel position write strobe |
| pos_val | input | 16·NCH | Per-channel signed Q1.15 position, channel i in bits 16·i+15:16·i |
| pwm_out | output | NCH | Edge-aligned servo pulse outputs, high-true |
| frame_start | output | 1 | One-cycle strobe at each counter wrap |
| tick_count | output | TICK_W | Saturating count of completed frames |

## Verification
The assertions check the following on every cycle:
- The counter stays in range.
- frame_start is one cycle wide and coincides with a zero count.
- Each active compare stays stable except in a frame_start cycle.
- An output that has fallen stays low until the next frame.
- tick_count moves only on a frame and sticks at all ones.

The pulse widths produced by the fixed-point mapping, the one-frame deferral of the shadow load (including a write that lands exactly on the wrap edge), and the isolation between channels only show up in the bench's measured frames. There, high-time counts are compared against a reference model of the queue and active registers.

// File: rtl/servo_pwm_pkg.sv
`timescale 1ns/1ps
package servo_pwm_pkg;

    localparam int POS_W = 16;

    typedef logic signed [POS_W-1:0] pos_t;

    // Timebase events produced each clock
    typedef struct packed {
        logic tick;   // prescaled counter advances this cycle
        logic wrap;   // counter returns to zero at this edge
    } timebase_t;

    // Prescaled ticks elapsed in a given number of microseconds
    function automatic longint us_to_ticks(longint tick_hz, longint us);
        return (tick_hz * us) / 64'd1_000_000;
    endfunction

    // Signed Q1.15 position to compare count; 0x7FFF is treated as +1
    function automatic logic [31:0] pos_to_cmp(pos_t p, logic [31:0] min_c,
                                               logic [31:0] span);
        logic [16:0] u;
        logic [48:0] prod;
        if (p == 16'sh7FFF) u = 17'h10000;
        else                u = {1'b0, ~p[POS_W-1], p[POS_W-2:0]};
        prod = {32'b0, u} * {17'b0, span};
        return min_c + prod[47:16];
    endfunction

endpackage

// File: rtl/servo_prescaler.sv
`timescale 1ns/1ps
module servo_prescaler #(
    parameter int PRESC_LOG2 = 6
) (
    input  logic clk,
    input  logic rst,
    output logic tick_en
);
    generate
        if (PRESC_LOG2 == 0) begin : g_nodiv
            assign tick_en = 1'b1;
        end else begin : g_div
            logic [PRESC_LOG2-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst) div_q <= '0;
                else     div_q <= div_q + 1'b1;
            end
            assign tick_en = &div_q;
        end
    endgenerate
endmodule

// File: rtl/servo_period_counter.sv
`timescale 1ns/1ps
module servo_period_counter
    import servo_pwm_pkg::*;
#(
    parameter int MODV  = 39062,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt,
    output timebase_t        tb
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MODV - 1);

    always_comb begin
        tb.tick = tick_en;
        tb.wrap = tick_en && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (tb.wrap) cnt <= '0;
        else if (tb.tick) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/servo_channel.sv
`timescale 1ns/1ps
module servo_channel
    import servo_pwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_CMP = 2148,
    parameter int SPAN    = 742
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  pos_t             pos,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] active_cmp,
    output logic             pwm
);
    localparam logic [CNT_W-1:0] NEUTRAL =
        CNT_W'(pos_to_cmp(16'sd0, 32'(MIN_CMP), 32'(SPAN)));

    logic [CNT_W-1:0] queue_q;
    logic [CNT_W-1:0] conv;

    assign conv = CNT_W'(pos_to_cmp(pos, 32'(MIN_CMP), 32'(SPAN)));

    always_ff @(posedge clk) begin
        if (rst) begin
            queue_q    <= NEUTRAL;
            active_cmp <= NEUTRAL;
        end else begin
            if (wr)   queue_q    <= conv;
            if (wrap) active_cmp <= queue_q;
        end
    end

    // set at wrap (cnt==0), cleared on compare match
    assign pwm = (cnt < active_cmp);
endmodule

// File: rtl/servo_tick_counter.sv
`timescale 1ns/1ps
module servo_tick_counter #(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    output logic [TICK_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)                    count <= '0;
        else if (wrap && !(&count)) count <= count + 1'b1;
    end
endmodule

// File: rtl/servo_frame_pwm.sv
`timescale 1ns/1ps
module servo_frame_pwm
    import servo_pwm_pkg::*;
#(
    parameter int NCH          = 2,
    parameter int CLK_HZ       = 125_000_000,
    parameter int PRESC_LOG2   = 6,
    parameter int PERIOD_US    = 20000,
    parameter int MIN_US       = 1100,
    parameter int MAX_US       = 1480,
    parameter int TICK_W       = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        pos_wr,
    input  logic [NCH*POS_W-1:0]  pos_val,
    output logic [NCH-1:0]        pwm_out,
    output logic                  frame_start,
    output logic [TICK_W-1:0]     tick_count
);
    localparam longint TICK_HZ = longint'(CLK_HZ) >> PRESC_LOG2;
    localparam int MODV    = int'(us_to_ticks(TICK_HZ, PERIOD_US));
    localparam int MIN_CMP = int'(us_to_ticks(TICK_HZ, MIN_US));
    localparam int MAX_CMP = int'(us_to_ticks(TICK_HZ, MAX_US));
    localparam int SPAN    = MAX_CMP - MIN_CMP;
    localparam int CNT_W   = $clog2(MODV + 1);

    logic             tick_en;
    logic [CNT_W-1:0] cnt_q;
    timebase_t        tb;
    logic [NCH*CNT_W-1:0] active_flat;

    servo_prescaler #(.PRESC_LOG2(PRESC_LOG2)) u_presc (
        .clk(clk), .rst(rst), .tick_en(tick_en)
    );

    servo_period_counter #(.MODV(MODV), .CNT_W(CNT_W)) u_period (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cnt(cnt_q), .tb(tb)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            servo_channel #(.CNT_W(CNT_W), .MIN_CMP(MIN_CMP), .SPAN(SPAN)) u_ch (
                .clk        (clk),
                .rst        (rst),
                .wr         (pos_wr[g]),
                .pos        (pos_val[g*POS_W +: POS_W]),
                .wrap       (tb.wrap),
                .cnt        (cnt_q),
                .active_cmp (active_flat[g*CNT_W +: CNT_W]),
                .pwm        (pwm_out[g])
            );
        end
    endgenerate

    servo_tick_counter #(.TICK_W(TICK_W)) u_ticks (
        .clk(clk), .rst(rst), .wrap(tb.wrap), .count(tick_count)
    );

    always_ff @(posedge clk) begin
        if (rst) frame_start <= 1'b0;
        else     frame_start <= tb.wrap;
    end
endmodule

// File: rtl/servo_pwm_chk.sv
`timescale 1ns/1ps
module servo_pwm_chk #(
    parameter int NCH    = 2,
    parameter int CNT_W  = 16,
    parameter int MODV   = 39062,
    parameter int TICK_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CNT_W-1:0]     cnt,
    input logic [NCH*CNT_W-1:0] active_flat,
    input logic [NCH-1:0]       pwm_out,
    input logic                 frame_start,
    input logic [TICK_W-1:0]    tick_count
);
    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(MODV));

    // R1
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R1
    frame_zero_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (cnt == '0));

    // R6
    tick_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (&tick_count) |=> (&tick_count));

    // R6
    tick_only_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_count != $past(tick_count)) |-> frame_start);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chk
            // R4
            shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !frame_start |-> $stable(active_flat[i*CNT_W +: CNT_W]));

            // R2
            pwm_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !pwm_out[i] |=> (!pwm_out[i] || frame_start));
        end
    endgenerate
endmodule

bind servo_frame_pwm servo_pwm_chk #(
    .NCH(NCH), .CNT_W(CNT_W), .MODV(MODV), .TICK_W(TICK_W)
) u_chk (
    .clk(clk), .rst(rst), .cnt(cnt_q), .active_flat(active_flat),
    .pwm_out(pwm_out), .frame_start(frame_start), .tick_count(tick_count)
);

// File: tb/servo_frame_pwm_test.sv
`timescale 1ns/1ps
module servo_frame_pwm_test;
    // bench timebase: tick = 1 MHz/4 -> MODV 100, MIN 25, MAX 50
    localparam int PRESC = 4;
    localparam int MODV  = 100;
    localparam int MINC  = 25;
    localparam int SPANC = 25;
    localparam int FLEN  = MODV * PRESC;
    localparam int TMAX  = 15;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  pos_wr;
    logic [31:0] pos_val;
    logic [1:0]  pwm_out;
    logic        frame_start;
    logic [3:0]  tick_count;

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    int q_m [2];
    int a_m [2];
    int frames = 0;

    always #4 clk = ~clk;

    servo_frame_pwm #(
        .NCH(2), .CLK_HZ(1_000_000), .PRESC_LOG2(2), .PERIOD_US(400),
        .MIN_US(100), .MAX_US(200), .TICK_W(4)
    ) uut (
        .clk(clk), .rst(rst), .pos_wr(pos_wr), .pos_val(pos_val),
        .pwm_out(pwm_out), .frame_start(frame_start), .tick_count(tick_count)
    );

    function automatic int exp_cmp(logic signed [15:0] p);
        longint u;
        if (p == 16'sh7FFF) u = 65536;
        else                u = longint'(p) + 32768;
        return MINC + int'((u * SPANC) / 65536);
    endfunction

    task automatic check(string req, int act, int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input int wr_at, input logic [1:0] mask,
                             input logic signed [15:0] v0,
                             input logic signed [15:0] v1,
                             output int h0, output int h1, output int len);
        h0 = 0; h1 = 0; len = 0;
        do begin
            if (pwm_out[0]) h0++;
            if (pwm_out[1]) h1++;
            if (len == wr_at) begin
                pos_wr  = mask;
                pos_val = {v1, v0};
            end
            @(negedge clk);
            pos_wr = '0;
            len++;
        end while (!frame_start && len < 2 * FLEN);
    endtask

    // one frame with optional write, then model update and checks
    task automatic do_frame(input int wr_at, input logic [1:0] mask,
                            input logic signed [15:0] v0,
                            input logic signed [15:0] v1, input string tag);
        int h0, h1, len;
        int qn [2];
        int qo [2];
        qo = q_m;
        qn = q_m;
        if (wr_at >= 0) begin
            if (mask[0]) qn[0] = exp_cmp(v0);
            if (mask[1]) qn[1] = exp_cmp(v1);
        end
        run_frame(wr_at, mask, v0, v1, h0, h1, len);
        check({"R1 frame length ", tag}, len, FLEN);
        check({"R2 ch0 high time ", tag}, h0, a_m[0] * PRESC);
        check({"R2 ch1 high time ", tag}, h1, a_m[1] * PRESC);
        for (int c = 0; c < 2; c++)
            a_m[c] = (wr_at == FLEN - 1) ? qo[c] : qn[c];
        q_m = qn;
        frames++;
        check({"R6 tick count ", tag}, int'(tick_count),
              (frames > TMAX) ? TMAX : frames);
    endtask

    initial begin
        int cyc;
        void'($urandom(32'd20240611));
        rst = 1'b1; pos_wr = '0; pos_val = '0;
        repeat (5) @(negedge clk);
        // R5: reset state
        check("R5 tick_count at reset", int'(tick_count), 0);
        check("R5 frame_start at reset", int'(frame_start), 0);
        check("R5 outputs high at reset", int'(pwm_out), 3);
        rst = 1'b0;
        cyc = 0;
        while (!frame_start && cyc < 2 * FLEN) begin
            @(negedge clk); cyc++;
        end
        check("R1 first frame after reset", cyc, FLEN);
        frames = 1;
        check("R6 first tick", int'(tick_count), 1);
        for (int c = 0; c < 2; c++) begin q_m[c] = 37; a_m[c] = 37; end
        check("R3 neutral model value", exp_cmp(16'sd0), 37);

        // R5: neutral pulse width with no writes
        do_frame(-1, 2'b00, 16'sd0, 16'sd0, "neutral");
        // R4/R3: mid-frame write to both, extremes (R3 -1 -> 25, +1 clamp -> 50)
        do_frame(10, 2'b11, 16'sh8000, 16'sh7FFF, "R4 midframe write");
        do_frame(-1, 2'b00, 16'sd0, 16'sd0, "R3 extremes applied");
        // R7: write channel 0 only
        do_frame(300, 2'b01, 16'sd0, 16'sh1234, "R7 ch0 only");
        do_frame(-1, 2'b00, 16'sd0, 16'sd0, "R7 ch1 unchanged");
        // R4: write on the wrap edge is deferred one more frame
        do_frame(FLEN - 1, 2'b11, -16'sd16384, 16'sd16384, "R4 write at wrap");
        do_frame(-1, 2'b00, 16'sd0, 16'sd0, "R4 deferred");
        do_frame(-1, 2'b00, 16'sd0, 16'sd0, "R4 applied");
        // R4: last of two writes in a frame wins
        do_frame(50, 2'b11, 16'sh7FFE, 16'sh8001, "R4 first write");
        do_frame(5, 2'b10, 16'sd0, 16'sh4000, "R4 second write");

        // random frames, also drives the counter into saturation (R6)
        for (int k = 0; k < 16; k++) begin
            int wa;
            logic [1:0] m;
            logic signed [15:0] r0, r1;
            wa = ($urandom_range(0, 4) == 0) ? -1 : int'($urandom_range(0, FLEN - 1));
            m  = 2'($urandom_range(1, 3));
            r0 = 16'($urandom);
            r1 = 16'($urandom);
            if (k == 3) r0 = 16'sh7FFF;
            if (k == 7) r1 = 16'sh8000;
            do_frame(wa, m, r0, r1, "random");
        end
        check("R6 saturated", int'(tick_count), TMAX);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            vecs++; errs++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule